// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a synthesizable behavioural model of a synchronous static RAM with burst support. Each word is 18 bits wide and is split into two 9-bit byte lanes. Each lane holds eight data bits and one parity bit. The address and control inputs are registered on the rising clock edge. Read data is not registered on the way out: the word at the registered address drives the bidirectional data bus during the same cycle that starts after that edge. An output enable gates the bus drivers with no clock involved.

An access starts on one of two address strobes. The processor strobe only counts when the first chip enable is asserted, and it always starts a read. The controller strobe can start a read or a write. Once an access has started, the burst advance input steps a 2-bit counter through four addresses in linear or interleaved order. The address wraps back to where it started. Holding the advance input high freezes the counter. A write uses the global write input for both lanes or the byte-write input with per-lane enables. A nap input parks the block with its bus released. The address port is 18 bits wide. The on-chip store only decodes its low `STORE_AW` bits.

Top module: `flowthru_burst_sram`

## Requirements
- R1: While `rst` is high, and after it is released, nothing is selected and `dq` is released (high impedance). It stays released until a read is started.
- R2: A strobe starts an access only if `sel_a_n` is low, `sel_b` is high and `sel_c_n` is low. A strobe that finds any of the three enables deasserted ends the access and releases `dq`.
- R3: A low `cpu_strb_n` is ignored while `sel_a_n` is high. A burst in progress then continues unchanged.
- R4: When both strobes are low in the same cycle, the processor strobe wins. A cycle it starts is always a read, even with write inputs asserted, and no store location changes.
- R5: `ilv_order` high selects interleaved order: the low two address bits are the start bits XOR k, for k = 0,1,2,3. `ilv_order` low selects linear order: the start bits plus k, modulo 4. The upper address bits stay fixed for the whole burst.
- R6: In a cycle of an active access with `burst_adv_n` high, the burst position does not change. The same address is read or written again.
- R7: After four advances the burst returns to its starting address.
- R8: A low `ctl_strb_n` during a burst loads the new address and restarts the burst at position 0.
- R9: A cycle writes when `wr_all_n` is low (both lanes), or when `wr_byte_n` is low with at least one low bit of `lane_wr_n`. Bit 0 selects `dq[8:0]` and bit 1 selects `dq[17:9]`. Data is taken from `dq` at the same edge. On a strobe edge the write goes to the strobed address. In a continuing cycle it goes to the burst address after any advance at that edge. A processor-started read may be followed by such a write cycle.
- R10: A cycle with no write condition is a read. Data for the address registered at an edge appears on `dq` before the next edge.
- R11: After a write cycle, `dq` stays released in the continuing read cycles that follow. It drives again only after a read is started by a strobe.
- R12: `out_en_n` high releases `dq`, and low lets a pending read drive it, with no clock edge needed.
- R13: While `nap` is high, `dq` is released and the synchronous inputs are ignored, so no write takes place. After `nap` falls, `dq` stays released until a new read is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Word address, registered by a strobe |
| sel_a_n | input | 1 | First chip enable, active low; also gates the processor strobe |
| sel_b | input | 1 | Second chip enable, active high |
| sel_c_n | input | 1 | Third chip enable, active low |
| cpu_strb_n | input | 1 | Processor address strobe, active low |
| ctl_strb_n | input | 1 | Controller address strobe, active low |
| burst_adv_n | input | 1 | Burst advance, active low; high suspends the burst |
| wr_all_n | input | 1 | Global write, active low, both lanes |
| wr_byte_n | input | 1 | Byte-write qualifier, active low |
| lane_wr_n | input | 2 | Per-lane write enables, active low |
| ilv_order | input | 1 | Burst order: 1 interleaved, 0 linear; static |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| nap | input | 1 | Sleep request, active high |
| dq | inout | 18 | Bidirectional data bus, lane 1 on bits 17:9 |

## Verification
Several functions can fall in the same cycle. A controller strobe can arrive while a burst is advancing, and both strobes can arrive together with write inputs asserted. The bench provokes each of these on one edge. It judges the first by whether `dq` shows the new address rather than the next burst step. It judges the second by whether the stored word is unchanged when it is read back. A write can also be followed by read cycles that keep advancing. Here the bench expects the bus to stay released. A behavioural model in the bench, updated on every edge, predicts `dq` for each cycle of these overlaps.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    localparam int LANES  = 2;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;
    localparam int SEQ_W  = 2;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_LOAD_RD,
        OP_LOAD_WR,
        OP_CONT_RD,
        OP_CONT_WR,
        OP_DESEL,
        OP_SLEEP
    } op_e;

    typedef struct packed {
        op_e              op;
        logic             step;
        logic [LANES-1:0] wmask;
    } cmd_t;

    // Low address bits for burst position k from a start value.
    function automatic logic [SEQ_W-1:0] seq_low(
        input logic [SEQ_W-1:0] start,
        input logic [SEQ_W-1:0] k,
        input logic             ilv
    );
        return ilv ? (start ^ k) : (start + k);
    endfunction

    // Lanes that a cycle would write, given the raw write inputs.
    function automatic logic [LANES-1:0] lane_mask(
        input logic             all_n,
        input logic             byte_n,
        input logic [LANES-1:0] lanes_n
    );
        if (!all_n)
            return '1;
        else if (!byte_n)
            return ~lanes_n;
        else
            return '0;
    endfunction

endpackage

// File: rtl/sbs_cmd_decode.sv
module sbs_cmd_decode
    import sbs_pkg::*;
(
    input  logic             cpu_strb_n,
    input  logic             ctl_strb_n,
    input  logic             sel_a_n,
    input  logic             sel_b,
    input  logic             sel_c_n,
    input  logic             burst_adv_n,
    input  logic             wr_all_n,
    input  logic             wr_byte_n,
    input  logic [LANES-1:0] lane_wr_n,
    input  logic             nap,
    input  logic             active,
    output cmd_t             cmd
);

    logic             chip_sel;
    logic             cpu_hit;
    logic [LANES-1:0] wmask;
    op_e              op;

    always_comb begin
        chip_sel = !sel_a_n && sel_b && !sel_c_n;
        cpu_hit  = !cpu_strb_n && !sel_a_n;
        wmask    = lane_mask(wr_all_n, wr_byte_n, lane_wr_n);
        if (nap)
            op = OP_SLEEP;
        else if (cpu_hit)
            op = chip_sel ? OP_LOAD_RD : OP_DESEL;
        else if (!ctl_strb_n)
            op = chip_sel ? ((|wmask) ? OP_LOAD_WR : OP_LOAD_RD) : OP_DESEL;
        else if (active)
            op = (|wmask) ? OP_CONT_WR : OP_CONT_RD;
        else
            op = OP_IDLE;
        cmd.op    = op;
        cmd.step  = !burst_adv_n;
        cmd.wmask = wmask;
    end

    // R3: with the first enable high no strobe may start an access
    always_comb begin
        if (sel_a_n)
            p_gate_cpu_r3: assert (cmd.op != OP_LOAD_RD && cmd.op != OP_LOAD_WR);
    end

    // R4: a processor-started cycle is never a write
    always_comb begin
        if (!cpu_strb_n && !sel_a_n)
            p_cpu_reads_r4: assert (cmd.op != OP_LOAD_WR);
    end

endmodule

// File: rtl/sbs_burst_seq.sv
module sbs_burst_seq
    import sbs_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  cmd_t          cmd,
    input  logic [AW-1:0] load_addr,
    input  logic          ilv,
    output logic [AW-1:0] rd_addr,
    output logic [AW-1:0] wr_addr,
    output logic          active,
    output logic          rd_now
);

    localparam int HI_W = AW - SEQ_W;

    logic [HI_W-1:0]  hi_q;
    logic [SEQ_W-1:0] lo_q;
    logic [SEQ_W-1:0] cnt_q;
    logic [SEQ_W-1:0] cnt_step;
    logic             rd_en_q;
    logic             is_load;

    always_comb begin
        is_load  = (cmd.op == OP_LOAD_RD) || (cmd.op == OP_LOAD_WR);
        cnt_step = cnt_q + SEQ_W'(cmd.step);
        rd_addr  = {hi_q, seq_low(lo_q, cnt_q, ilv)};
        wr_addr  = is_load ? load_addr : {hi_q, seq_low(lo_q, cnt_step, ilv)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q    <= '0;
            lo_q    <= '0;
            cnt_q   <= '0;
            active  <= 1'b0;
            rd_en_q <= 1'b0;
            rd_now  <= 1'b0;
        end else begin
            case (cmd.op)
                OP_LOAD_RD: begin
                    hi_q    <= load_addr[AW-1:SEQ_W];
                    lo_q    <= load_addr[SEQ_W-1:0];
                    cnt_q   <= '0;
                    active  <= 1'b1;
                    rd_en_q <= 1'b1;
                    rd_now  <= 1'b1;
                end
                OP_LOAD_WR: begin
                    hi_q    <= load_addr[AW-1:SEQ_W];
                    lo_q    <= load_addr[SEQ_W-1:0];
                    cnt_q   <= '0;
                    active  <= 1'b1;
                    rd_en_q <= 1'b0;
                    rd_now  <= 1'b0;
                end
                OP_CONT_RD: begin
                    cnt_q  <= cnt_step;
                    rd_now <= rd_en_q;
                end
                OP_CONT_WR: begin
                    cnt_q   <= cnt_step;
                    rd_en_q <= 1'b0;
                    rd_now  <= 1'b0;
                end
                OP_DESEL, OP_SLEEP: begin
                    active  <= 1'b0;
                    rd_en_q <= 1'b0;
                    rd_now  <= 1'b0;
                end
                default: begin
                    rd_now <= 1'b0;
                end
            endcase
        end
    end

    // R10: a strobe read drives from position 0 in the next cycle
    p_start_read_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == OP_LOAD_RD) |=> (rd_now && active && cnt_q == '0));

    // R8: a strobe write restarts the burst at position 0
    p_restart_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == OP_LOAD_WR) |=> (active && cnt_q == '0));

    // R6: no advance, no movement
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        ((cmd.op == OP_CONT_RD || cmd.op == OP_CONT_WR) && !cmd.step) |=> $stable(cnt_q));

    // R7: the fourth advance returns to the start
    p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        ((cmd.op == OP_CONT_RD || cmd.op == OP_CONT_WR) && cmd.step && cnt_q == 2'd3)
        |=> (cnt_q == 2'd0));

    // R11: a write never leaves a read pending
    p_quiet_after_write_r11: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == OP_LOAD_WR || cmd.op == OP_CONT_WR) |=> !rd_now);

    // R2: a failed select ends the access
    p_deselect_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == OP_DESEL) |=> (!active && !rd_now));

    // R13: nap leaves nothing selected
    p_nap_clears_r13: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == OP_SLEEP) |=> (!active && !rd_now));

endmodule

// File: rtl/sbs_store.sv
module sbs_store
    import sbs_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LANES-1:0]  we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we[g])
                mem[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = mem[raddr];

        // R9: an enabled lane holds the written data after the edge
        p_lane_write_r9: assert property (@(posedge clk) disable iff (rst)
            we[g] |=> (mem[$past(waddr)] == $past(wdata[g*LANE_W +: LANE_W])));
    end

endmodule

// File: rtl/flowthru_burst_sram.sv
module flowthru_burst_sram
    import sbs_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int STORE_AW = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              cpu_strb_n,
    input  logic              ctl_strb_n,
    input  logic              burst_adv_n,
    input  logic              wr_all_n,
    input  logic              wr_byte_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic              ilv_order,
    input  logic              out_en_n,
    input  logic              nap,
    inout  wire  [WORD_W-1:0] dq
);

    cmd_t                cmd;
    logic                active;
    logic                rd_now;
    logic [STORE_AW-1:0] rd_addr;
    logic [STORE_AW-1:0] wr_addr;
    logic [LANES-1:0]    we;
    logic [WORD_W-1:0]   rdata;
    logic [WORD_W-1:0]   wdata;
    logic                drive;
    logic                unused_addr_hi;

    assign unused_addr_hi = ^addr[ADDR_W-1:STORE_AW];

    sbs_cmd_decode u_dec (
        .cpu_strb_n  (cpu_strb_n),
        .ctl_strb_n  (ctl_strb_n),
        .sel_a_n     (sel_a_n),
        .sel_b       (sel_b),
        .sel_c_n     (sel_c_n),
        .burst_adv_n (burst_adv_n),
        .wr_all_n    (wr_all_n),
        .wr_byte_n   (wr_byte_n),
        .lane_wr_n   (lane_wr_n),
        .nap         (nap),
        .active      (active),
        .cmd         (cmd)
    );

    sbs_burst_seq #(.AW(STORE_AW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .load_addr (addr[STORE_AW-1:0]),
        .ilv       (ilv_order),
        .rd_addr   (rd_addr),
        .wr_addr   (wr_addr),
        .active    (active),
        .rd_now    (rd_now)
    );

    assign we    = (cmd.op == OP_LOAD_WR || cmd.op == OP_CONT_WR) ? cmd.wmask : '0;
    assign wdata = dq;

    sbs_store #(.AW(STORE_AW)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (we),
        .waddr (wr_addr),
        .wdata (wdata),
        .raddr (rd_addr),
        .rdata (rdata)
    );

    assign drive = rd_now & ~out_en_n & ~nap;
    assign dq    = drive ? rdata : 'z;

endmodule

// File: tb/flowthru_burst_sram_test.sv
`timescale 1ns/1ps
module flowthru_burst_sram_test;

    localparam logic [17:0] FLOAT = 18'h3FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [17:0] addr = '0;
    logic        sel_a_n = 1'b0, sel_b = 1'b1, sel_c_n = 1'b0;
    logic        cpu_strb_n = 1'b1, ctl_strb_n = 1'b1, burst_adv_n = 1'b1;
    logic        wr_all_n = 1'b1, wr_byte_n = 1'b1;
    logic [1:0]  lane_wr_n = 2'b11;
    logic        ilv_order = 1'b0, out_en_n = 1'b1, nap = 1'b0;
    logic        drv_en = 1'b0;
    logic [17:0] drv_val = '0;
    wire  [17:0] dq;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    assign dq = drv_en ? drv_val : 18'bz;
    for (genvar gi = 0; gi < 18; gi++) begin : g_pu
        pullup (dq[gi]);
    end

    always #10 clk = ~clk;

    flowthru_burst_sram uut (
        .clk(clk), .rst(rst), .addr(addr),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .cpu_strb_n(cpu_strb_n), .ctl_strb_n(ctl_strb_n), .burst_adv_n(burst_adv_n),
        .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_wr_n(lane_wr_n),
        .ilv_order(ilv_order), .out_en_n(out_en_n), .nap(nap), .dq(dq)
    );

    // ---------------- reference model ----------------
    logic [17:0] m_mem [0:511];
    bit          m_act = 0, m_rdok = 0, m_drv = 0;
    int          m_base = 0, m_cnt = 0;

    function automatic logic [17:0] pat(input int a);
        return 18'h01234 + 18'(a) * 18'h00211;
    endfunction

    function automatic int m_cur();
        int lo;
        lo = ilv_order ? ((m_base & 3) ^ m_cnt) : (((m_base & 3) + m_cnt) & 3);
        return (m_base & ~3) | lo;
    endfunction

    task automatic m_write(input int a, input int wm);
        if ((wm & 1) != 0) m_mem[a % 512][8:0]  = dq[8:0];
        if ((wm & 2) != 0) m_mem[a % 512][17:9] = dq[17:9];
    endtask

    always @(posedge clk) begin
        int wm;
        bit sel;
        wm  = !wr_all_n ? 3 : (!wr_byte_n ? (int'(~lane_wr_n) & 3) : 0);
        sel = !sel_a_n && sel_b && !sel_c_n;
        if (rst || nap) begin
            m_act = 0; m_rdok = 0; m_drv = 0;
        end else if (!cpu_strb_n && !sel_a_n) begin
            if (sel) begin m_base = int'(addr); m_cnt = 0; m_act = 1; m_rdok = 1; m_drv = 1; end
            else begin m_act = 0; m_rdok = 0; m_drv = 0; end
        end else if (!ctl_strb_n) begin
            if (sel) begin
                m_base = int'(addr); m_cnt = 0; m_act = 1;
                if (wm != 0) begin m_write(m_base, wm); m_rdok = 0; m_drv = 0; end
                else begin m_rdok = 1; m_drv = 1; end
            end else begin m_act = 0; m_rdok = 0; m_drv = 0; end
        end else if (m_act) begin
            if (!burst_adv_n) m_cnt = (m_cnt + 1) % 4;
            if (wm != 0) begin m_write(m_cur(), wm); m_rdok = 0; m_drv = 0; end
            else m_drv = m_rdok;
        end else begin
            m_drv = 0;
        end
    end

    // compare against the model every cycle, 4 ns after the edge
    always @(posedge clk) begin
        logic [17:0] exp;
        #4;
        if (!rst && !drv_en) begin
            exp = (m_drv && !out_en_n && !nap) ? m_mem[m_cur() % 512] : FLOAT;
            checks++;
            if (dq !== exp) begin
                errors++;
                $display("FAIL %s (model): dq=%h expected %h at %0t", cur_req, dq, exp, $time);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic step();
        @(posedge clk);
        #5;
    endtask

    task automatic chk(input logic [17:0] exp, input string req);
        checks++;
        if (dq !== exp) begin
            errors++;
            $display("FAIL %s: dq=%h expected %h at %0t", req, dq, exp, $time);
        end
    endtask

    task automatic idle_in();
        cpu_strb_n = 1; ctl_strb_n = 1; burst_adv_n = 1;
        wr_all_n = 1; wr_byte_n = 1; lane_wr_n = 2'b11;
        sel_a_n = 0; sel_b = 1; sel_c_n = 0; drv_en = 0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    // ---------------- directed sequence ----------------
    initial begin
        for (int i = 0; i < 512; i++) m_mem[i] = '0;
        idle_in();
        out_en_n = 0;
        repeat (3) step();
        chk(FLOAT, "R1");
        rst = 0;
        step();
        chk(FLOAT, "R1");

        // fill addresses 0..63 with linear write bursts (R9)
        cur_req = "R9";
        out_en_n = 1;
        ilv_order = 0;
        for (int b = 0; b < 16; b++) begin
            addr = 18'(b * 4); ctl_strb_n = 0; wr_all_n = 0;
            drv_en = 1; drv_val = pat(b * 4); burst_adv_n = 1;
            step();
            ctl_strb_n = 1; burst_adv_n = 0;
            for (int k = 1; k < 4; k++) begin
                drv_val = pat(b * 4 + k);
                step();
            end
        end
        idle_in();
        out_en_n = 0;

        // linear burst from 6 (R5, R7, R10)
        cur_req = "R5";
        addr = 18'd6; ctl_strb_n = 0;
        step(); chk(pat(6), "R10");
        ctl_strb_n = 1; burst_adv_n = 0;
        step(); chk(pat(7), "R5");
        step(); chk(pat(4), "R5");
        step(); chk(pat(5), "R5");
        step(); chk(pat(6), "R7");

        // suspend (R6)
        cur_req = "R6";
        burst_adv_n = 1;
        step(); chk(pat(6), "R6");
        step(); chk(pat(6), "R6");
        burst_adv_n = 0;
        step(); chk(pat(7), "R6");

        // processor strobe with first enable high is ignored (R3)
        cur_req = "R3";
        burst_adv_n = 1; cpu_strb_n = 0; sel_a_n = 1; addr = 18'h20;
        step(); chk(pat(7), "R3");
        cpu_strb_n = 1; sel_a_n = 0;

        // deselect by enables (R2)
        cur_req = "R2";
        ctl_strb_n = 0; sel_c_n = 1;
        step(); chk(FLOAT, "R2");
        sel_c_n = 0; addr = 18'd2;
        step(); chk(pat(2), "R2");
        sel_b = 0;
        step(); chk(FLOAT, "R2");
        idle_in();

        // interleaved burst from 9 via processor strobe (R5, R7)
        cur_req = "R5";
        ilv_order = 1;
        addr = 18'd9; cpu_strb_n = 0;
        step(); chk(pat(9), "R10");
        cpu_strb_n = 1; burst_adv_n = 0;
        step(); chk(pat(8), "R5");
        step(); chk(pat(11), "R5");
        step(); chk(pat(10), "R5");
        step(); chk(pat(9), "R7");

        // controller strobe restarts mid-burst (R8)
        cur_req = "R8";
        addr = 18'h21; ctl_strb_n = 0;
        step(); chk(pat(33), "R8");
        ctl_strb_n = 1;
        step(); chk(pat(32), "R8");
        idle_in();
        ilv_order = 0;

        // both strobes with write asserted: read wins, no write (R4)
        cur_req = "R4";
        out_en_n = 1;
        addr = 18'h0C; cpu_strb_n = 0; ctl_strb_n = 0; wr_all_n = 0;
        drv_en = 1; drv_val = 18'h00ABC;
        step();
        idle_in();
        out_en_n = 0;
        #1 chk(pat(12), "R4");
        #4;
        step(); chk(pat(12), "R4");

        // processor read followed by a lane-0 write (R9)
        cur_req = "R9";
        out_en_n = 1;
        addr = 18'h10; cpu_strb_n = 0;
        step();
        cpu_strb_n = 1; wr_byte_n = 0; lane_wr_n = 2'b10;
        drv_en = 1; drv_val = 18'h15A5A;
        step();
        idle_in(); out_en_n = 0;
        addr = 18'h10; ctl_strb_n = 0;
        step(); chk({pat(16)[17:9], 9'h05A}, "R9");
        // global write
        out_en_n = 1; addr = 18'h11; wr_all_n = 0;
        drv_en = 1; drv_val = 18'h2468A;
        step();
        idle_in(); out_en_n = 0; addr = 18'h11; ctl_strb_n = 0;
        step(); chk(18'h2468A, "R9");
        // byte qualifier high: no write, read instead
        out_en_n = 1; addr = 18'h12; wr_byte_n = 1; lane_wr_n = 2'b00;
        step();
        idle_in(); out_en_n = 0;
        #1 chk(pat(18), "R9");
        #4;
        // lane-1-only write
        out_en_n = 1; addr = 18'h13; ctl_strb_n = 0; wr_byte_n = 0; lane_wr_n = 2'b01;
        drv_en = 1; drv_val = 18'h0F0F0;
        step();
        idle_in(); out_en_n = 0; addr = 18'h13; ctl_strb_n = 0;
        step(); chk({9'(18'h0F0F0 >> 9), pat(19)[8:0]}, "R9");
        idle_in();

        // bus stays released after a write (R11)
        cur_req = "R11";
        out_en_n = 1; addr = 18'h14; ctl_strb_n = 0; wr_all_n = 0;
        drv_en = 1; drv_val = 18'h13579;
        step();
        idle_in(); burst_adv_n = 0; out_en_n = 0;
        step(); chk(FLOAT, "R11");
        step(); chk(FLOAT, "R11");
        burst_adv_n = 1; addr = 18'h14; ctl_strb_n = 0;
        step(); chk(18'h13579, "R11");
        ctl_strb_n = 1;

        // asynchronous output enable (R12)
        cur_req = "R12";
        out_en_n = 1;
        #1 chk(FLOAT, "R12");
        out_en_n = 0;
        #1 chk(18'h13579, "R12");
        #3;

        // nap (R13)
        cur_req = "R13";
        sel_b = 0; ctl_strb_n = 0;
        step(); chk(FLOAT, "R2");
        idle_in();
        out_en_n = 1; nap = 1;
        addr = 18'h15; ctl_strb_n = 0; wr_all_n = 0;
        drv_en = 1; drv_val = 18'h00777;
        step();
        step();
        idle_in(); out_en_n = 0;
        #1 chk(FLOAT, "R13");
        #2;
        addr = 18'h15; ctl_strb_n = 0;
        #1 chk(FLOAT, "R13");
        #1;
        ctl_strb_n = 1; nap = 0;
        step(); chk(FLOAT, "R13");
        addr = 18'h15; ctl_strb_n = 0;
        step(); chk(pat(21), "R13");
        ctl_strb_n = 1;

        // reset releases a driving bus (R1)
        cur_req = "R1";
        rst = 1;
        step(); chk(FLOAT, "R1");
        rst = 0;
        step(); chk(FLOAT, "R1");

        finish_run();
    end

endmodule